// File: doc/BRIEF.md
# Anchored Signature Matcher with Parallel State Bits

This block scans one network payload, a byte at a time, for a single fixed intrusion signature. The payload must open with the exact text "NetBus", then carry one or more whitespace bytes, then one or more decimal digits. The matcher is a non-deterministic automaton. Each state is one flip-flop, and all flip-flops advance together on every accepted byte. A literal stage passes its token forward only on an equal byte. The two class stages, whitespace and digit, can each also keep their own token alive through a self-loop.

A start-of-payload strobe clears the automaton and arms a seed bit, so that only the first byte of the payload can begin the match. A small phase machine watches the next-state vector and records the outcome. It has four states. `PH_IDLE` is the state after reset, before any payload. `PH_SCAN` means some state bit is still live. `PH_HIT` means the digit stage has fired. `PH_MISS` means every state bit is dead. Its transitions are: any state goes to `PH_SCAN` on the strobe; `PH_SCAN` goes to `PH_HIT` when the digit stage turns on; `PH_SCAN` goes to `PH_MISS` when no state bit survives a byte; `PH_HIT` and `PH_MISS` hold until the next strobe. A done pulse marks the end of the payload, and at that point the match flag holds the final verdict.

Top module: `sig_nfa_matcher`

## Requirements
- R1: After reset, `match_o` and `done_o` are 0, and bytes that arrive before any start strobe never raise `match_o`. Asserting reset also clears a match that is already set.
- R2: The pattern is anchored. "NetBus" must start at the first accepted byte after `sop`, so "xNetBus 1" and "NetBusNetBus 1" do not match. The seed bit is never re-armed by a later byte.
- R3: The literal stages compare bytes exactly and are case-sensitive, in the order N(0x4E) e(0x65) t(0x74) B(0x42) u(0x75) s(0x73). "netBus 1" and "NetBUs 1" do not match.
- R4: At least one whitespace byte must follow "NetBus". The whitespace class is exactly 0x20, 0x09, 0x0A, 0x0B, 0x0C and 0x0D. "NetBus1" and "NetBus"+0x08+"8" do not match. "NetBus"+0x0B+0x0C+"7" matches.
- R5: The whitespace stage keeps itself active through any run of further whitespace bytes.
- R6: At least one digit, 0x30 to 0x39, must follow the whitespace, and the digit stage loops on further digits. 0x2F, 0x3A, a letter, or the end of the payload after the whitespace gives no match.
- R7: `match_o` rises in the cycle after the clock edge that accepts the first digit byte, and is 0 before that edge. It then stays 1 through any trailing bytes until the next `sop`.
- R8: `sop` clears `match_o` and every state bit, and arms only the seed bit. A byte that is presented with `byte_vld` in the same cycle as `sop` is ignored. A new `sop` in the middle of a payload restarts the match.
- R9: When `byte_vld` is 0, the state bits and `match_o` keep their values, whatever `byte_data` carries.
- R10: `done_o` is a one-cycle pulse in the cycle after a byte accepted with `byte_last` = 1 (and `sop` = 0). At that point `match_o` holds the final result for the payload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; does not arm the seed |
| sop | input | 1 | Start-of-payload strobe; clears and arms the automaton |
| byte_vld | input | 1 | A payload byte is presented this cycle |
| byte_last | input | 1 | The presented byte is the final byte of the payload |
| byte_data | input | 8 | Payload byte |
| match_o | output | 1 | Signature found in the current payload (sticky) |
| done_o | output | 1 | One-cycle pulse after the last byte |

## Verification
The bench builds the block with its default parameters: a six-character literal "NetBus", which gives a chain of six literal stages between the seed and the two class stages. With this setting every stage can be reached by a failing byte, from a wrong first byte to a missing digit at the end. The class boundaries can also be reached with neighbouring codes (0x08, 0x2F, 0x3A). Payloads are made long enough to show that the whitespace and digit self-loops hold over runs of several bytes.

// File: rtl/sig_nfa_pkg.sv
package sig_nfa_pkg;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_SCAN,
        PH_HIT,
        PH_MISS
    } phase_e;

    typedef enum logic {
        CLS_SPACE,
        CLS_DIGIT
    } class_e;

    function automatic logic is_space(input logic [7:0] b);
        return (b == 8'h20) || ((b >= 8'h09) && (b <= 8'h0D));
    endfunction

    function automatic logic is_digit(input logic [7:0] b);
        return (b >= 8'h30) && (b <= 8'h39);
    endfunction

endpackage

// File: rtl/nfa_lit_stage.sv
module nfa_lit_stage #(
    parameter logic [7:0] CHAR = 8'h00
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       adv,
    input  logic       tok_in,
    input  logic [7:0] byte_in,
    output logic       tok_d,
    output logic       tok_q
);

    always_comb begin
        tok_d = tok_q;
        if (clr)
            tok_d = 1'b0;
        else if (adv)
            tok_d = tok_in && (byte_in == CHAR);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            tok_q <= 1'b0;
        else
            tok_q <= tok_d;
    end

endmodule

// File: rtl/nfa_rep_stage.sv
module nfa_rep_stage
    import sig_nfa_pkg::*;
#(
    parameter class_e CLS = CLS_SPACE
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       adv,
    input  logic       tok_in,
    input  logic [7:0] byte_in,
    output logic       tok_d,
    output logic       tok_q
);

    logic cls_hit;

    generate
        if (CLS == CLS_DIGIT) begin : g_digit
            assign cls_hit = is_digit(byte_in);
        end else begin : g_space
            assign cls_hit = is_space(byte_in);
        end
    endgenerate

    always_comb begin
        tok_d = tok_q;
        if (clr)
            tok_d = 1'b0;
        else if (adv)
            tok_d = (tok_in || tok_q) && cls_hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            tok_q <= 1'b0;
        else
            tok_q <= tok_d;
    end

endmodule

// File: rtl/nfa_phase_fsm.sv
module nfa_phase_fsm
    import sig_nfa_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sop,
    input  logic adv,
    input  logic final_d,
    input  logic live_d,
    output logic match_o
);

    phase_e phase_q, phase_d;

    always_comb begin
        phase_d = phase_q;
        if (sop) begin
            phase_d = PH_SCAN;
        end else begin
            unique case (phase_q)
                PH_IDLE: phase_d = PH_IDLE;
                PH_SCAN: begin
                    if (adv) begin
                        if (final_d)
                            phase_d = PH_HIT;
                        else if (!live_d)
                            phase_d = PH_MISS;
                    end
                end
                PH_HIT:  phase_d = PH_HIT;
                PH_MISS: phase_d = PH_MISS;
                default: phase_d = PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            phase_q <= PH_IDLE;
        else
            phase_q <= phase_d;
    end

    always_comb begin
        match_o = (phase_q == PH_HIT);
    end

endmodule

// File: rtl/sig_nfa_matcher.sv
module sig_nfa_matcher
    import sig_nfa_pkg::*;
#(
    parameter int               LIT_LEN  = 6,
    parameter logic [8*LIT_LEN-1:0] LIT_TEXT = "NetBus"
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sop,
    input  logic       byte_vld,
    input  logic       byte_last,
    input  logic [7:0] byte_data,
    output logic       match_o,
    output logic       done_o
);

    localparam int LAST = LIT_LEN - 1;

    logic               adv;
    logic               arm_q, arm_d;
    logic [LIT_LEN-1:0] lit_q, lit_d, lit_in;
    logic               ws_q, ws_d;
    logic               dig_q, dig_d;
    logic               live_d;
    logic               done_q;

    assign adv = byte_vld && !sop;

    // seed bit: armed by the strobe, consumed by the first byte
    always_comb begin
        arm_d = arm_q;
        if (sop)
            arm_d = 1'b1;
        else if (adv)
            arm_d = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            arm_q <= 1'b0;
        else
            arm_q <= arm_d;
    end

    assign lit_in = {lit_q[LIT_LEN-2:0], arm_q};

    generate
        for (genvar i = 0; i < LIT_LEN; i++) begin : g_lit
            nfa_lit_stage #(
                .CHAR (LIT_TEXT[8*(LAST-i) +: 8])
            ) u_lit (
                .clk     (clk),
                .rst_n   (rst_n),
                .clr     (sop),
                .adv     (adv),
                .tok_in  (lit_in[i]),
                .byte_in (byte_data),
                .tok_d   (lit_d[i]),
                .tok_q   (lit_q[i])
            );
        end
    endgenerate

    nfa_rep_stage #(.CLS(CLS_SPACE)) u_ws (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (sop),
        .adv     (adv),
        .tok_in  (lit_q[LAST]),
        .byte_in (byte_data),
        .tok_d   (ws_d),
        .tok_q   (ws_q)
    );

    nfa_rep_stage #(.CLS(CLS_DIGIT)) u_dig (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (sop),
        .adv     (adv),
        .tok_in  (ws_q),
        .byte_in (byte_data),
        .tok_d   (dig_d),
        .tok_q   (dig_q)
    );

    assign live_d = arm_d || (|lit_d) || ws_d || dig_d;

    nfa_phase_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .sop     (sop),
        .adv     (adv),
        .final_d (dig_d),
        .live_d  (live_d),
        .match_o (match_o)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            done_q <= 1'b0;
        else
            done_q <= adv && byte_last;
    end

    assign done_o = done_q;

endmodule

// File: rtl/sig_nfa_checker.sv
module sig_nfa_checker #(
    parameter int LIT_LEN = 6
) (
    input logic               clk,
    input logic               rst_n,
    input logic               sop,
    input logic               byte_vld,
    input logic               byte_last,
    input logic               match_o,
    input logic               done_o,
    input logic               arm_q,
    input logic [LIT_LEN-1:0] lit_q
);

    // R7
    match_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (match_o && !sop) |=> match_o);

    // R8
    sop_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sop |=> (!match_o && arm_q && (lit_q == '0)));

    // R2
    no_reseed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_vld && !sop) |=> !arm_q);

    // R2
    single_prefix_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({lit_q, arm_q}));

    // R9
    hold_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!byte_vld && !sop) |=> ($stable(lit_q) && $stable(arm_q) && $stable(match_o)));

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_vld && byte_last && !sop) |=> done_o);

    // R10
    done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(byte_vld && byte_last && !sop) |=> !done_o);

endmodule

bind sig_nfa_matcher sig_nfa_checker #(.LIT_LEN(LIT_LEN)) chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sop       (sop),
    .byte_vld  (byte_vld),
    .byte_last (byte_last),
    .match_o   (match_o),
    .done_o    (done_o),
    .arm_q     (arm_q),
    .lit_q     (lit_q)
);

// File: tb/sig_nfa_matcher_test.sv
module sig_nfa_matcher_test;

    localparam time CLK_PERIOD = 10ns;
    localparam int  NV = 15;

    localparam logic [191:0] TV_TXT [NV] = '{
        "NetBus 1",
        "NetBus \t\r\n 42",
        "netBus 1",
        "NetBUs 1",
        "NetBus1",
        "NetBus\v\f7",
        "NetBus\0108",
        "NetBus x",
        "NetBus /",
        "NetBus :",
        "xNetBus 1",
        "NetBus 9zz",
        "NetBus 0123456789",
        "NetBus  ",
        "NetBusNetBus 1"
    };
    localparam bit TV_EXP [NV] = '{1, 1, 0, 0, 0, 1, 0, 0, 0, 0, 0, 1, 1, 0, 0};
    localparam logic [15:0] TV_TAG [NV] = '{
        "R7", "R5", "R3", "R3", "R4", "R4", "R4", "R6",
        "R6", "R6", "R2", "R7", "R6", "R6", "R2"
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sop = 1'b0;
    logic       byte_vld = 1'b0;
    logic       byte_last = 1'b0;
    logic [7:0] byte_data = 8'h00;
    logic       match_o;
    logic       done_o;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    sig_nfa_matcher uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .sop       (sop),
        .byte_vld  (byte_vld),
        .byte_last (byte_last),
        .byte_data (byte_data),
        .match_o   (match_o),
        .done_o    (done_o)
    );

    task automatic check_eq(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int txt_len(input logic [191:0] t);
        for (int k = 23; k >= 0; k--)
            if (t[8*k +: 8] != 8'h00) return k + 1;
        return 0;
    endfunction

    task automatic send_sop();
        sop = 1'b1;
        byte_vld = 1'b0;
        @(negedge clk);
        sop = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b, input bit last);
        byte_data = b;
        byte_vld  = 1'b1;
        byte_last = last;
        @(negedge clk);
        byte_vld  = 1'b0;
        byte_last = 1'b0;
    endtask

    task automatic send_text(input logic [191:0] t, input bit last_on_end);
        int n;
        n = txt_len(t);
        for (int i = 0; i < n; i++)
            send_byte(t[8*(n-1-i) +: 8], last_on_end && (i == n - 1));
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        int wd;
        wd = 0;
        while (!finished && wd < 100000) begin
            @(posedge clk);
            wd++;
        end
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got %0d expected %0d", wd, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R1: reset state
        check_eq("R1", match_o, 0);
        check_eq("R1", done_o, 0);

        // R1: bytes with no strobe never match
        send_text("NetBus 1", 1'b1);
        check_eq("R1", match_o, 0);
        idle(1);

        // vector table
        for (int v = 0; v < NV; v++) begin
            send_sop();
            send_text(TV_TXT[v], 1'b1);
            check_eq($sformatf("%s vec%0d done", TV_TAG[v], v), done_o, 1);
            check_eq($sformatf("%s vec%0d match", TV_TAG[v], v), match_o, int'(TV_EXP[v]));
            idle(1);
            check_eq($sformatf("R10 vec%0d done drop", v), done_o, 0);
        end

        // R7: exact timing of the match rise
        send_sop();
        send_text("NetBus ", 1'b0);
        check_eq("R7 before digit", match_o, 0);
        send_byte("3", 1'b0);
        check_eq("R7 after digit", match_o, 1);
        send_text("ab", 1'b1);
        check_eq("R7 trailing", match_o, 1);
        check_eq("R10 done", done_o, 1);

        // R8: strobe clears a held match
        send_sop();
        check_eq("R8 clear", match_o, 0);
        idle(1);

        // R8: byte in the strobe cycle is ignored
        sop = 1'b1;
        byte_vld = 1'b1;
        byte_data = "N";
        @(negedge clk);
        sop = 1'b0;
        byte_vld = 1'b0;
        check_eq("R8 no done on sop byte", done_o, 0);
        send_text("etBus 1", 1'b1);
        check_eq("R8 sop byte ignored", match_o, 0);
        idle(1);

        // R8: mid-payload restart
        send_sop();
        send_text("Net", 1'b0);
        send_sop();
        send_text("NetBus 2", 1'b1);
        check_eq("R8 restart", match_o, 1);
        idle(1);

        // R9: gaps in byte_vld do not disturb state
        send_sop();
        send_text("Net", 1'b0);
        byte_data = "X";
        idle(3);
        send_text("Bus 5", 1'b1);
        check_eq("R9 gap", match_o, 1);
        idle(1);

        // R1: reset clears a held match
        rst_n = 1'b0;
        idle(1);
        rst_n = 1'b1;
        idle(1);
        check_eq("R1 reset clears", match_o, 0);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule